// File: doc/BRIEF.md
# Multi-Range Up/Down Counter with Programmable Comparator

This block counts single-cycle steps up or down. A step comes from an external qualified pulse or from one of seven internal timebases. The count is held in one of four runtime-selectable ranges: signed or unsigned, 16 or 32 bits wide. At a range limit the counter either saturates and raises a sticky overflow or underflow flag (linear mode), or wraps to the opposite limit (ring mode).

A preset strobe loads a new count and a latch strobe captures a snapshot of the count. A comparator tests the live count against a programmable value using one of six relations. Both operands are read in the active range, so the same bit patterns can compare differently in signed and unsigned ranges.

Typical use is position or event counting, where the match output drives downstream event logic and the latched value holds a captured position.

Top module: `multi_counter`

## Requirements
- R1: While reset is high, and after it is released, the count, the latched value and both flags are zero until something changes them.
- R2: On source code 0, the count moves by one on each clock edge where count_en and pulse_in are both high: up when up_dn is 1, down when it is 0. A pulse without count_en has no effect.
- R3: Source codes 1 to 7 step the count on internal ticks with periods of 25 ns, 50 ns, 100 ns, 1 us, 10 us, 100 us and 1 ms, at the clock period given by a parameter (5 ns by default, so code 1 gives one tick every 5 cycles). After the code changes, the first tick comes on the (divider+1)-th edge.
- R4: In linear mode (ring_mode=0), a step past the upper limit holds the count at the limit and sets ovf_flag. A step past the lower limit holds the count and sets udf_flag. Both flags stay set until a preset or reset.
- R5: In ring mode (ring_mode=1), a step past the upper limit loads the lower limit, and a step past the lower limit loads the upper limit. Neither flag changes.
- R6: range_sel selects the range: 0 = signed 32, 1 = unsigned 32, 2 = signed 16, 3 = unsigned 16. In the 16-bit ranges only bits 15:0 of the count matter, and the stored count is sign-extended (range 2) or zero-extended (range 3) to 32 bits.
- R7: preset_stb loads preset_val, read in the active range, and clears both flags. It overrides any step on the same edge.
- R8: latch_stb makes latch_val equal to the count as it was just before that edge, even when the count changes on the same edge.
- R9: cmp_match compares the count with cmp_val, both read in the active range. cmp_rel selects the relation: 0 equal, 1 greater, 2 less, 3 greater-or-equal, 4 less-or-equal, 5 not-equal. Codes 6 and 7 give 0. The output follows its inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_en | input | 1 | Gate for all counting steps |
| pulse_in | input | 1 | External single-cycle count pulse |
| up_dn | input | 1 | 1 counts up, 0 counts down |
| clk_src | input | 3 | 0 external pulse, 1..7 internal timebase |
| range_sel | input | 2 | Counting range code |
| ring_mode | input | 1 | 1 wrap, 0 saturate |
| preset_stb | input | 1 | Load preset_val |
| preset_val | input | 32 | Value to load |
| latch_stb | input | 1 | Capture current count |
| cmp_val | input | 32 | Comparison operand |
| cmp_rel | input | 3 | Comparison relation code |
| count_val | output | 32 | Current count |
| latch_val | output | 32 | Captured count |
| ovf_flag | output | 1 | Sticky overflow (linear mode) |
| udf_flag | output | 1 | Sticky underflow (linear mode) |
| cmp_match | output | 1 | Comparison result |

## Verification
The assertions assume that the range selection does not change between a preset and the checks that depend on it. They also assume that count_val is only compared directly against cmp_val in the unsigned 32-bit range, where no extension applies. The stimulus holds each range for a whole segment and presets the counter at the start of each segment, with values near that range's limits. It also keeps the external source selected during random runs, so the timebase is exercised only in directed segments.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    localparam int unsigned CNT_W  = 32;
    localparam int unsigned HALF_W = CNT_W / 2;
    localparam int unsigned WIDE_W = CNT_W + 1;

    typedef enum logic [1:0] {
        RNG_S32 = 2'd0,
        RNG_U32 = 2'd1,
        RNG_S16 = 2'd2,
        RNG_U16 = 2'd3
    } range_e;

    typedef enum logic [2:0] {
        REL_EQ = 3'd0,
        REL_GT = 3'd1,
        REL_LT = 3'd2,
        REL_GE = 3'd3,
        REL_LE = 3'd4,
        REL_NE = 3'd5
    } rel_e;

    typedef logic signed [WIDE_W-1:0] wide_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             udf;
    } cnt_state_t;

    // Interpret a stored pattern in the selected range as a wide signed value.
    function automatic wide_t to_wide(input logic [CNT_W-1:0] v, input range_e r);
        wide_t w;
        case (r)
            RNG_S32: w = wide_t'({v[CNT_W-1], v});
            RNG_U32: w = wide_t'({1'b0, v});
            RNG_S16: w = wide_t'({{(WIDE_W-HALF_W){v[HALF_W-1]}}, v[HALF_W-1:0]});
            default: w = wide_t'({{(WIDE_W-HALF_W){1'b0}}, v[HALF_W-1:0]});
        endcase
        return w;
    endfunction

    function automatic wide_t range_hi(input range_e r);
        wide_t w;
        case (r)
            RNG_S32: w = wide_t'({2'b00, {(CNT_W-1){1'b1}}});
            RNG_U32: w = wide_t'({1'b0, {CNT_W{1'b1}}});
            RNG_S16: w = wide_t'({{(WIDE_W-HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}});
            default: w = wide_t'({{(WIDE_W-HALF_W){1'b0}}, {HALF_W{1'b1}}});
        endcase
        return w;
    endfunction

    function automatic wide_t range_lo(input range_e r);
        wide_t w;
        case (r)
            RNG_S32: w = wide_t'({2'b11, {(CNT_W-1){1'b0}}});
            RNG_S16: w = wide_t'({{(WIDE_W-HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}});
            default: w = '0;
        endcase
        return w;
    endfunction

    // Timebase period in picoseconds for each internal source code.
    function automatic int unsigned src_period_ps(input logic [2:0] code);
        int unsigned p;
        case (code)
            3'd1:    p = 32'd25_000;
            3'd2:    p = 32'd50_000;
            3'd3:    p = 32'd100_000;
            3'd4:    p = 32'd1_000_000;
            3'd5:    p = 32'd10_000_000;
            3'd6:    p = 32'd100_000_000;
            default: p = 32'd1_000_000_000;
        endcase
        return p;
    endfunction

    function automatic int unsigned src_div(input logic [2:0] code, input int unsigned clk_ps);
        int unsigned d;
        d = src_period_ps(code) / clk_ps;
        return (d == 0) ? 32'd1 : d;
    endfunction

endpackage

// File: rtl/cnt_timebase.sv
module cnt_timebase
    import cnt_pkg::*;
#(
    parameter int unsigned CLK_PS = 5000,
    parameter int unsigned DIV_W  = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] src,
    output logic       tick
);
    logic [2:0]       src_q;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_lim;

    always_comb begin
        div_lim = DIV_W'(src_div(src, CLK_PS) - 1);
    end

    assign tick = (src == src_q) && (src != 3'd0) && (div_cnt == div_lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= 3'd0;
            div_cnt <= '0;
        end else begin
            src_q <= src;
            if (src != src_q || div_cnt == div_lim)
                div_cnt <= '0;
            else
                div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cnt_core.sv
module cnt_core
    import cnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             up,
    input  range_e           rng,
    input  logic             ring,
    input  logic             preset,
    input  logic [CNT_W-1:0] preset_val,
    input  logic             latch,
    output cnt_state_t       state,
    output logic [CNT_W-1:0] latched
);
    cnt_state_t st_q, st_d;
    logic [CNT_W-1:0] lat_q;
    wide_t cur_w, hi_w, lo_w, nxt_w, pre_w;

    always_comb begin
        cur_w = to_wide(st_q.cnt, rng);
        hi_w  = range_hi(rng);
        lo_w  = range_lo(rng);
        pre_w = to_wide(preset_val, rng);
        nxt_w = cur_w;
        st_d  = st_q;
        if (preset) begin
            st_d.cnt = pre_w[CNT_W-1:0];
            st_d.ovf = 1'b0;
            st_d.udf = 1'b0;
        end else if (step) begin
            if (up) begin
                if (cur_w == hi_w) begin
                    if (ring) nxt_w = lo_w;
                    else      st_d.ovf = 1'b1;
                end else begin
                    nxt_w = cur_w + wide_t'(1);
                end
            end else begin
                if (cur_w == lo_w) begin
                    if (ring) nxt_w = hi_w;
                    else      st_d.udf = 1'b1;
                end else begin
                    nxt_w = cur_w - wide_t'(1);
                end
            end
            st_d.cnt = nxt_w[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            lat_q <= '0;
        end else begin
            st_q <= st_d;
            if (latch) lat_q <= st_q.cnt;
        end
    end

    assign state   = st_q;
    assign latched = lat_q;
endmodule

// File: rtl/cnt_compare.sv
module cnt_compare
    import cnt_pkg::*;
(
    input  logic [CNT_W-1:0] a,
    input  logic [CNT_W-1:0] b,
    input  range_e           rng,
    input  logic [2:0]       rel,
    output logic             match
);
    wide_t aw, bw;

    always_comb begin
        aw = to_wide(a, rng);
        bw = to_wide(b, rng);
        case (rel)
            REL_EQ:  match = (aw == bw);
            REL_GT:  match = (aw >  bw);
            REL_LT:  match = (aw <  bw);
            REL_GE:  match = (aw >= bw);
            REL_LE:  match = (aw <= bw);
            REL_NE:  match = (aw != bw);
            default: match = 1'b0;
        endcase
    end
endmodule

// File: rtl/multi_counter.sv
module multi_counter
    import cnt_pkg::*;
#(
    parameter int unsigned CLK_PS = 5000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        count_en,
    input  logic        pulse_in,
    input  logic        up_dn,
    input  logic [2:0]  clk_src,
    input  logic [1:0]  range_sel,
    input  logic        ring_mode,
    input  logic        preset_stb,
    input  logic [31:0] preset_val,
    input  logic        latch_stb,
    input  logic [31:0] cmp_val,
    input  logic [2:0]  cmp_rel,
    output logic [31:0] count_val,
    output logic [31:0] latch_val,
    output logic        ovf_flag,
    output logic        udf_flag,
    output logic        cmp_match
);
    range_e     rng;
    logic       tb_tick;
    logic       step;
    cnt_state_t state;

    assign rng  = range_e'(range_sel);
    assign step = count_en && ((clk_src == 3'd0) ? pulse_in : tb_tick);

    cnt_timebase #(.CLK_PS(CLK_PS)) u_tb (
        .clk  (clk),
        .rst  (rst),
        .src  (clk_src),
        .tick (tb_tick)
    );

    cnt_core u_core (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .up         (up_dn),
        .rng        (rng),
        .ring       (ring_mode),
        .preset     (preset_stb),
        .preset_val (preset_val),
        .latch      (latch_stb),
        .state      (state),
        .latched    (latch_val)
    );

    cnt_compare u_cmp (
        .a     (state.cnt),
        .b     (cmp_val),
        .rng   (rng),
        .rel   (cmp_rel),
        .match (cmp_match)
    );

    assign count_val = state.cnt;
    assign ovf_flag  = state.ovf;
    assign udf_flag  = state.udf;
endmodule

// File: rtl/multi_counter_chk.sv
module multi_counter_chk (
    input logic        clk,
    input logic        rst,
    input logic        count_en,
    input logic [1:0]  range_sel,
    input logic        ring_mode,
    input logic        preset_stb,
    input logic [31:0] preset_val,
    input logic        latch_stb,
    input logic [31:0] cmp_val,
    input logic [2:0]  cmp_rel,
    input logic [31:0] count_val,
    input logic [31:0] latch_val,
    input logic        ovf_flag,
    input logic        udf_flag,
    input logic        cmp_match
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (count_val == 32'd0 && latch_val == 32'd0 && !ovf_flag && !udf_flag));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!count_en && !preset_stb) |=> $stable(count_val));

    assert_sticky_ovf_R4: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !preset_stb) |=> ovf_flag);

    assert_sticky_udf_R4: assert property (@(posedge clk) disable iff (rst)
        (udf_flag && !preset_stb) |=> udf_flag);

    assert_ring_no_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (ring_mode && !ovf_flag && !udf_flag) |=> (!ovf_flag && !udf_flag));

    assert_s16_extend_R6: assert property (@(posedge clk) disable iff (rst)
        (preset_stb && range_sel == 2'd2) |=> (count_val[31:16] == {16{count_val[15]}}));

    assert_preset_load_R7: assert property (@(posedge clk) disable iff (rst)
        (preset_stb && range_sel == 2'd1) |=> (count_val == $past(preset_val) && !ovf_flag && !udf_flag));

    assert_latch_prior_R8: assert property (@(posedge clk) disable iff (rst)
        latch_stb |=> (latch_val == $past(count_val)));

    assert_cmp_eq_R9: assert property (@(posedge clk) disable iff (rst)
        (range_sel == 2'd1 && cmp_rel == 3'd0) |-> (cmp_match == (count_val == cmp_val)));

    assert_cmp_bad_rel_R9: assert property (@(posedge clk) disable iff (rst)
        (cmp_rel[2:1] == 2'b11) |-> !cmp_match);
endmodule

bind multi_counter multi_counter_chk u_chk (.*);

// File: tb/multi_counter_tb.sv
`timescale 1ns/1ps
module multi_counter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        count_en = 1'b0, pulse_in = 1'b0, up_dn = 1'b1;
    logic [2:0]  clk_src = 3'd0;
    logic [1:0]  range_sel = 2'd0;
    logic        ring_mode = 1'b0;
    logic        preset_stb = 1'b0;
    logic [31:0] preset_val = '0;
    logic        latch_stb = 1'b0;
    logic [31:0] cmp_val = '0;
    logic [2:0]  cmp_rel = 3'd0;
    logic [31:0] count_val, latch_val;
    logic        ovf_flag, udf_flag, cmp_match;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_cnt = '0, m_lat = '0;
    logic        m_ovf = 1'b0, m_udf = 1'b0;

    always #2.5 clk = ~clk;

    multi_counter u_dut (
        .clk(clk), .rst(rst), .count_en(count_en), .pulse_in(pulse_in), .up_dn(up_dn),
        .clk_src(clk_src), .range_sel(range_sel), .ring_mode(ring_mode),
        .preset_stb(preset_stb), .preset_val(preset_val), .latch_stb(latch_stb),
        .cmp_val(cmp_val), .cmp_rel(cmp_rel), .count_val(count_val), .latch_val(latch_val),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag), .cmp_match(cmp_match)
    );

    function automatic longint wv(input logic [31:0] v, input logic [1:0] r);
        case (r)
            2'd0:    return v[31] ? longint'(v) - 64'sd4294967296 : longint'(v);
            2'd1:    return longint'(v);
            2'd2:    return v[15] ? longint'(v[15:0]) - 64'sd65536 : longint'(v[15:0]);
            default: return longint'(v[15:0]);
        endcase
    endfunction

    function automatic longint hi_of(input logic [1:0] r);
        case (r)
            2'd0:    return 64'sd2147483647;
            2'd1:    return 64'sd4294967295;
            2'd2:    return 64'sd32767;
            default: return 64'sd65535;
        endcase
    endfunction

    function automatic longint lo_of(input logic [1:0] r);
        case (r)
            2'd0:    return -64'sd2147483648;
            2'd2:    return -64'sd32768;
            default: return 64'sd0;
        endcase
    endfunction

    function automatic logic exp_match(input logic [31:0] c, input logic [31:0] v,
                                       input logic [1:0] r, input logic [2:0] rel);
        longint a, b;
        a = wv(c, r);
        b = wv(v, r);
        case (rel)
            3'd0:    return a == b;
            3'd1:    return a > b;
            3'd2:    return a < b;
            3'd3:    return a >= b;
            3'd4:    return a <= b;
            3'd5:    return a != b;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Advance the reference model by one edge with the currently driven inputs (external source).
    task automatic model_edge();
        longint w;
        if (latch_stb) m_lat = m_cnt;
        if (preset_stb) begin
            w = wv(preset_val, range_sel);
            m_cnt = w[31:0];
            m_ovf = 1'b0;
            m_udf = 1'b0;
        end else if (count_en && pulse_in && clk_src == 3'd0) begin
            w = wv(m_cnt, range_sel);
            if (up_dn) begin
                if (w == hi_of(range_sel)) begin
                    if (ring_mode) w = lo_of(range_sel); else m_ovf = 1'b1;
                end else w = w + 1;
            end else begin
                if (w == lo_of(range_sel)) begin
                    if (ring_mode) w = hi_of(range_sel); else m_udf = 1'b1;
                end else w = w - 1;
            end
            m_cnt = w[31:0];
        end
    endtask

    task automatic cyc(input string req);
        model_edge();
        @(posedge clk);
        #1;
        chk(req, "count", longint'(count_val), longint'(m_cnt));
        chk(req, "latch", longint'(latch_val), longint'(m_lat));
        chk(req, "ovf",   longint'(ovf_flag),  longint'(m_ovf));
        chk(req, "udf",   longint'(udf_flag),  longint'(m_udf));
        chk(req, "match", longint'(cmp_match),
            longint'(exp_match(m_cnt, cmp_val, range_sel, cmp_rel)));
        @(negedge clk);
        preset_stb = 1'b0;
        latch_stb  = 1'b0;
        pulse_in   = 1'b0;
    endtask

    task automatic do_preset(input logic [1:0] r, input logic ring, input logic [31:0] v, input string req);
        range_sel = r; ring_mode = ring; preset_val = v; preset_stb = 1'b1;
        cyc(req);
    endtask

    task automatic pulses(input int n, input logic up, input string req);
        for (int i = 0; i < n; i++) begin
            count_en = 1'b1; up_dn = up; pulse_in = 1'b1;
            cyc(req);
        end
    endtask

    initial begin
        #(5 * 150000);
        $display("FAIL watchdog: got timeout expected completion");
        fails++;
        checks++;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "count in reset", longint'(count_val), 0);
        rst = 1'b0;
        cyc("R1");

        // R2: external pulses, gating by count_en
        pulses(3, 1'b1, "R2");
        pulses(1, 1'b0, "R2");
        count_en = 1'b0; pulse_in = 1'b1;
        cyc("R2");
        chk("R2", "gated pulse ignored", longint'(count_val), 64'd2);

        // R4 / R5 signed 32
        do_preset(2'd0, 1'b0, 32'h7FFF_FFFE, "R7");
        pulses(3, 1'b1, "R4");
        chk("R4", "saturate s32", longint'(count_val), 64'h7FFF_FFFF);
        pulses(2, 1'b0, "R4");
        chk("R4", "ovf sticky", longint'(ovf_flag), 1);
        do_preset(2'd0, 1'b1, 32'h7FFF_FFFF, "R7");
        pulses(1, 1'b1, "R5");
        chk("R5", "ring wrap s32", longint'(count_val), 64'h8000_0000);
        pulses(1, 1'b0, "R5");
        chk("R5", "ring wrap back", longint'(count_val), 64'h7FFF_FFFF);

        // R6 ranges
        do_preset(2'd3, 1'b1, 32'hABCD_FFFF, "R6");
        chk("R6", "u16 zero-ext", longint'(count_val), 64'h0000_FFFF);
        pulses(1, 1'b1, "R6");
        chk("R6", "u16 wrap", longint'(count_val), 0);
        do_preset(2'd2, 1'b1, 32'h0000_8000, "R6");
        chk("R6", "s16 sign-ext", longint'(count_val), 64'hFFFF_8000);
        pulses(1, 1'b0, "R6");
        chk("R6", "s16 wrap down", longint'(count_val), 64'h0000_7FFF);
        do_preset(2'd1, 1'b0, 32'h0000_0001, "R6");
        pulses(3, 1'b0, "R4");
        chk("R4", "u32 udf", longint'(udf_flag), 1);
        chk("R4", "u32 floor", longint'(count_val), 0);

        // R7 / R8: preset beats step, latch sees old value
        count_en = 1'b1; pulse_in = 1'b1; up_dn = 1'b1;
        preset_val = 32'h0000_1234; preset_stb = 1'b1; latch_stb = 1'b1;
        cyc("R7");
        chk("R7", "preset overrides step", longint'(count_val), 64'h1234);
        chk("R7", "flags cleared", longint'(udf_flag), 0);
        chk("R8", "latch old value", longint'(latch_val), 0);
        latch_stb = 1'b1; pulse_in = 1'b1; count_en = 1'b1;
        cyc("R8");
        chk("R8", "latch before step", longint'(latch_val), 64'h1234);

        // R9 comparator
        do_preset(2'd0, 1'b0, 32'hFFFF_FFFF, "R9");
        cmp_val = 32'd1; cmp_rel = 3'd1; count_en = 1'b0;
        #1 chk("R9", "s32 -1 > 1", longint'(cmp_match), 0);
        range_sel = 2'd1;
        #1 chk("R9", "u32 max > 1", longint'(cmp_match), 1);
        range_sel = 2'd2; cmp_val = 32'h1234_0001; cmp_rel = 3'd2;
        #1 chk("R9", "s16 -1 < 1", longint'(cmp_match), 1);
        cmp_rel = 3'd6;
        #1 chk("R9", "bad rel", longint'(cmp_match), 0);
        for (int rel = 0; rel < 6; rel++) begin
            cmp_rel = 3'(rel); cmp_val = 32'h0000_FFFF; range_sel = 2'd3;
            #1 chk("R9", "u16 relation", longint'(cmp_match), longint'(exp_match(32'hFFFF_FFFF, cmp_val, 2'd3, 3'(rel))));
        end
        range_sel = 2'd0;
        @(negedge clk);

        // R3 internal timebase
        do_preset(2'd1, 1'b0, 32'd0, "R3");
        count_en = 1'b1; up_dn = 1'b1; clk_src = 3'd1;
        repeat (21) @(posedge clk);
        #1 chk("R3", "25ns source", longint'(count_val), 4);
        @(negedge clk);
        clk_src = 3'd2; preset_val = 32'd0; preset_stb = 1'b1;
        @(negedge clk);
        preset_stb = 1'b0;
        repeat (30) @(posedge clk);
        #1 chk("R3", "50ns source", longint'(count_val), 3);
        @(negedge clk);
        count_en = 1'b0; clk_src = 3'd0; m_ovf = 1'b0; m_udf = 1'b0;
        m_cnt = count_val;

        // Random segments on external source
        void'($urandom(32'd1234));
        for (int seg = 0; seg < 20; seg++) begin
            logic [1:0] r;
            longint base;
            r = 2'($urandom_range(0, 3));
            base = ($urandom_range(0, 1) == 1) ? hi_of(r) - 3 : lo_of(r) + 3;
            do_preset(r, 1'($urandom_range(0, 1)), base[31:0], "R6");
            for (int k = 0; k < 120; k++) begin
                count_en   = ($urandom_range(0, 9) < 7);
                pulse_in   = 1'($urandom_range(0, 1));
                up_dn      = ($urandom_range(0, 9) < ((seg % 2 == 0) ? 7 : 3));
                latch_stb  = ($urandom_range(0, 9) == 0);
                preset_stb = ($urandom_range(0, 49) == 0);
                preset_val = $urandom();
                cmp_rel    = 3'($urandom_range(0, 7));
                cmp_val    = ($urandom_range(0, 1) == 1) ? m_cnt : $urandom();
                cyc("R2");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule